// File: doc/BRIEF.md
# I2C Acknowledge Control Unit

This unit makes the acknowledge decision for every byte on an I2C bus. It also records the acknowledge returned by the far end. It sits beside a bit engine that shifts bits, detects START and STOP and drives SCL. That engine supplies a strobe when eight bits have been shifted in, and a level that is high for the whole ninth (acknowledge) clock. It also supplies a strobe at the moment SDA is to be sampled in that ninth clock. The unit answers with a request to pull SDA low during the acknowledge slot.

Address bytes and data bytes take separate paths. A slave accepts an address byte when it matches the programmed own address, unless automatic address acknowledge is disabled. It also accepts the general-call value 0x00 when a dedicated enable allows it. Data bytes are acknowledged according to a data-ack enable that is read live during the slot. In slave mode this also needs an address acknowledge earlier in the same transfer. This lets software inspect a received byte and then choose ack or nack, for example after a checksum test. A transfer-complete interrupt can be placed after the eighth clock or after the ninth. Each interrupt becomes a one-clock pulse and a pending flag that software clears.

Top module: `i2c_ack_ctrl`

## Requirements
- R1: After reset, sda_pull_o, irq_pulse_o and irq_pend_o are 0 and last_rx_ack_o is 1.
- R2: In slave mode (is_master_i = 0), the first byte after a START is an address byte. It is acknowledged when rx_byte_i[7:1] equals own_addr_i and addr_ack_dis_i = 0. A mismatch, or addr_ack_dis_i = 1, gives no acknowledge.
- R3: In slave mode, an address byte equal to 8'h00 is acknowledged only when gc_ack_en_i = 1.
- R4: In master mode, a received data byte (is_receiver_i = 1) is acknowledged exactly when data_ack_en_i = 1.
- R5: In slave mode, a received data byte is acknowledged only when data_ack_en_i = 1 and an address acknowledge was given since the last START or STOP.
- R6: A START or STOP clears the addressed state. A data byte after a STOP, with no new address match, is not acknowledged.
- R7: sda_pull_o is high only in the clock after a cycle with ack_phase_i = 1. It is never high for a data byte while is_receiver_i = 0.
- R8: On a cycle with ack_sample_i = 1, the level of sda_in_i is captured and appears on last_rx_ack_o on the next clock (0 = ack, 1 = nack). It holds at all other times.
- R9: With irq_at_8th_i = 1 at byte_done_i, irq_pulse_o is high for one clock on the next cycle. With irq_at_8th_i = 0 at ack_sample_i, the pulse follows ack_sample_i instead. Each strobe uses the select value current at that strobe.
- R10: irq_pend_o sets with every interrupt pulse and stays set until a cycle with irq_clr_i = 1 and no new interrupt. A new interrupt in the same cycle as the clear wins.
- R11: During the acknowledge slot, a data acknowledge follows data_ack_en_i with one clock of delay, so a late change of the enable still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start_i | input | 1 | START or repeated START seen (one-clock strobe) |
| bus_stop_i | input | 1 | STOP seen (one-clock strobe) |
| byte_done_i | input | 1 | Eighth clock finished, rx_byte_i valid (strobe) |
| rx_byte_i | input | 8 | Byte shifted in from the bus |
| ack_phase_i | input | 1 | High for the whole ninth clock |
| ack_sample_i | input | 1 | Ninth-clock SDA sampling moment (strobe) |
| sda_in_i | input | 1 | SDA level seen on the bus |
| is_master_i | input | 1 | 1 = master mode, 0 = slave mode |
| is_receiver_i | input | 1 | 1 = this device receives the data byte |
| own_addr_i | input | 7 | Own slave address |
| addr_ack_dis_i | input | 1 | 1 = no automatic address acknowledge |
| gc_ack_en_i | input | 1 | 1 = acknowledge the general-call address |
| data_ack_en_i | input | 1 | 1 = acknowledge received data bytes |
| irq_at_8th_i | input | 1 | 1 = interrupt after eighth clock, 0 = after ninth |
| irq_clr_i | input | 1 | Software clear of the pending interrupt |
| sda_pull_o | output | 1 | Request to drive SDA low |
| last_rx_ack_o | output | 1 | Last acknowledge level captured from the bus |
| irq_pulse_o | output | 1 | One-clock transfer-complete pulse |
| irq_pend_o | output | 1 | Pending transfer-complete flag |

## Verification
The assertions assume that the strobes behave as a real bit engine drives them. Each lasts one clock. START and STOP never coincide with byte_done_i. ack_sample_i falls inside an ack_phase_i window that follows byte_done_i. The mode inputs stay constant from byte_done_i until the slot closes. The bench builds every byte from one task that issues this exact order of strobes, and it changes only data_ack_en_i and irq_at_8th_i inside a byte. That matches the software behaviour the late-decision feature exists for.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;
    typedef enum logic [1:0] {
        KIND_NONE     = 2'd0,
        KIND_ADDR_ACK = 2'd1,
        KIND_ADDR_NAK = 2'd2,
        KIND_DATA     = 2'd3
    } byte_kind_e;

    typedef struct packed {
        logic       in_addr;
        logic       addressed;
        byte_kind_e kind;
        logic       sda_pull;
        logic       last_ack;
    } ack_state_t;

    typedef struct packed {
        logic pulse;
        logic pend;
    } irq_state_t;
endpackage

// File: rtl/i2c_ack_addr_match.sv
module i2c_ack_addr_match #(
    parameter int ADDR_W  = 7,
    parameter int GC_CODE = 0
) (
    input  logic [ADDR_W:0]   rx_byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              addr_ack_dis_i,
    input  logic              gc_ack_en_i,
    output logic              hit_o
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam logic [BYTE_W-1:0] GC_VAL = BYTE_W'(GC_CODE);

    logic own_hit;
    logic gc_hit;

    always_comb begin
        own_hit = (rx_byte_i[ADDR_W:1] == own_addr_i) && !addr_ack_dis_i;
        gc_hit  = (rx_byte_i == GC_VAL) && gc_ack_en_i;
        hit_o   = own_hit || gc_hit;
    end
endmodule

// File: rtl/i2c_ack_decide.sv
module i2c_ack_decide
    import i2c_ack_pkg::*;
(
    input  byte_kind_e kind_i,
    input  logic       is_master_i,
    input  logic       is_receiver_i,
    input  logic       addressed_i,
    input  logic       data_ack_en_i,
    output logic       want_ack_o
);
    always_comb begin
        unique case (kind_i)
            KIND_ADDR_ACK: want_ack_o = 1'b1;
            KIND_DATA:     want_ack_o = data_ack_en_i && is_receiver_i
                                        && (is_master_i || addressed_i);
            default:       want_ack_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_ack_irq.sv
module i2c_ack_irq
    import i2c_ack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_done_i,
    input  logic ack_sample_i,
    input  logic irq_at_8th_i,
    input  logic irq_clr_i,
    output logic irq_pulse_o,
    output logic irq_pend_o
);
    irq_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        fire       = (byte_done_i && irq_at_8th_i) || (ack_sample_i && !irq_at_8th_i);
        st_d.pulse = fire;
        st_d.pend  = fire || (st_q.pend && !irq_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pulse_o = st_q.pulse;
    assign irq_pend_o  = st_q.pend;

    a_r9_pulse_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |-> irq_pend_o);
    a_r10_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && !irq_clr_i) |=> irq_pend_o);
    a_r10_clear_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !byte_done_i && !ack_sample_i) |=> !irq_pend_o);
endmodule

// File: rtl/i2c_ack_ctrl.sv
module i2c_ack_ctrl
    import i2c_ack_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int GC_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start_i,
    input  logic              bus_stop_i,
    input  logic              byte_done_i,
    input  logic [ADDR_W:0]   rx_byte_i,
    input  logic              ack_phase_i,
    input  logic              ack_sample_i,
    input  logic              sda_in_i,
    input  logic              is_master_i,
    input  logic              is_receiver_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              addr_ack_dis_i,
    input  logic              gc_ack_en_i,
    input  logic              data_ack_en_i,
    input  logic              irq_at_8th_i,
    input  logic              irq_clr_i,
    output logic              sda_pull_o,
    output logic              last_rx_ack_o,
    output logic              irq_pulse_o,
    output logic              irq_pend_o
);
    ack_state_t st_d, st_q;
    logic       addr_hit;
    logic       want_ack;

    i2c_ack_addr_match #(.ADDR_W(ADDR_W), .GC_CODE(GC_CODE)) i_match (
        .rx_byte_i      (rx_byte_i),
        .own_addr_i     (own_addr_i),
        .addr_ack_dis_i (addr_ack_dis_i),
        .gc_ack_en_i    (gc_ack_en_i),
        .hit_o          (addr_hit)
    );

    i2c_ack_decide i_decide (
        .kind_i        (st_q.kind),
        .is_master_i   (is_master_i),
        .is_receiver_i (is_receiver_i),
        .addressed_i   (st_q.addressed),
        .data_ack_en_i (data_ack_en_i),
        .want_ack_o    (want_ack)
    );

    i2c_ack_irq i_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_done_i  (byte_done_i),
        .ack_sample_i (ack_sample_i),
        .irq_at_8th_i (irq_at_8th_i),
        .irq_clr_i    (irq_clr_i),
        .irq_pulse_o  (irq_pulse_o),
        .irq_pend_o   (irq_pend_o)
    );

    always_comb begin
        st_d = st_q;
        if (bus_start_i || bus_stop_i) begin
            st_d.in_addr   = bus_start_i;
            st_d.addressed = 1'b0;
            st_d.kind      = KIND_NONE;
        end else if (byte_done_i) begin
            st_d.in_addr = 1'b0;
            if (st_q.in_addr && !is_master_i) begin
                st_d.kind      = addr_hit ? KIND_ADDR_ACK : KIND_ADDR_NAK;
                st_d.addressed = addr_hit;
            end else begin
                st_d.kind = KIND_DATA;
            end
        end
        st_d.sda_pull = ack_phase_i && want_ack;
        if (ack_sample_i) st_d.last_ack = sda_in_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.kind     <= KIND_NONE;
            st_q.last_ack <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_pull_o    = st_q.sda_pull;
    assign last_rx_ack_o = st_q.last_ack;

    a_r7_pull_only_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> $past(ack_phase_i));
    a_r7_no_pull_as_sender: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o && $past(st_q.kind == KIND_DATA)) |-> $past(is_receiver_i));
    a_r5_slave_data_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o && $past(!is_master_i && st_q.kind == KIND_DATA)) |-> $past(st_q.addressed));
    a_r6_stop_clears_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop_i |=> !st_q.addressed);
    a_r8_capture_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_sample_i |=> (last_rx_ack_o == $past(sda_in_i)));
    a_r8_hold_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_sample_i |=> $stable(last_rx_ack_o));
endmodule

// File: tb/test_i2c_ack_ctrl.sv
module test_i2c_ack_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [6:0] OWN = 7'h3A;
    localparam int NVEC = 13;
    // fields: start, master, receiver, rx[7:0], dis, gc, dack, expected pull
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b1,1'b0,1'b1,8'h74,1'b0,1'b0,1'b1,1'b1}, // R2 match
        {1'b0,1'b0,1'b1,8'h5C,1'b0,1'b0,1'b1,1'b1}, // R5 data ack
        {1'b0,1'b0,1'b1,8'h11,1'b0,1'b0,1'b0,1'b0}, // R5 enable off
        {1'b0,1'b0,1'b0,8'h22,1'b0,1'b0,1'b1,1'b0}, // R7 sender
        {1'b1,1'b0,1'b1,8'h74,1'b1,1'b0,1'b1,1'b0}, // R2 auto ack disabled
        {1'b0,1'b0,1'b1,8'h33,1'b0,1'b0,1'b1,1'b0}, // R5 no address ack
        {1'b1,1'b0,1'b1,8'h00,1'b0,1'b1,1'b1,1'b1}, // R3 general call on
        {1'b0,1'b0,1'b1,8'h44,1'b0,1'b1,1'b1,1'b1}, // R5 after general call
        {1'b1,1'b0,1'b1,8'h00,1'b0,1'b0,1'b1,1'b0}, // R3 general call off
        {1'b1,1'b0,1'b1,8'h42,1'b0,1'b1,1'b1,1'b0}, // R2 mismatch
        {1'b0,1'b1,1'b1,8'h66,1'b0,1'b0,1'b1,1'b1}, // R4 master ack
        {1'b0,1'b1,1'b1,8'h77,1'b0,1'b0,1'b0,1'b0}, // R4 master nack
        {1'b0,1'b1,1'b0,8'h88,1'b0,1'b0,1'b1,1'b0}  // R7 master sender
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_start = 0, bus_stop = 0, byte_done = 0, ack_phase = 0, ack_sample = 0;
    logic sda_in = 1, is_master = 0, is_receiver = 1;
    logic [7:0] rx_byte = '0;
    logic addr_ack_dis = 0, gc_ack_en = 0, data_ack_en = 0, irq_at_8th = 0, irq_clr = 0;
    logic sda_pull, last_rx_ack, irq_pulse, irq_pend;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ack_ctrl i_i2c_ack_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_start_i(bus_start), .bus_stop_i(bus_stop),
        .byte_done_i(byte_done), .rx_byte_i(rx_byte), .ack_phase_i(ack_phase),
        .ack_sample_i(ack_sample), .sda_in_i(sda_in), .is_master_i(is_master),
        .is_receiver_i(is_receiver), .own_addr_i(OWN), .addr_ack_dis_i(addr_ack_dis),
        .gc_ack_en_i(gc_ack_en), .data_ack_en_i(data_ack_en), .irq_at_8th_i(irq_at_8th),
        .irq_clr_i(irq_clr), .sda_pull_o(sda_pull), .last_rx_ack_o(last_rx_ack),
        .irq_pulse_o(irq_pulse), .irq_pend_o(irq_pend)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pulse_start();
        bus_start = 1; tick(); bus_start = 0;
    endtask

    task automatic pulse_stop();
        bus_stop = 1; tick(); bus_stop = 0;
    endtask

    // one byte: byte_done, two-cycle slot with a sample in its second cycle
    task automatic run_byte(input logic [7:0] b, input logic exp_pull, input logic ack_lvl,
                            input string req);
        rx_byte = b; byte_done = 1; tick(); byte_done = 0;
        ack_phase = 1; tick();
        chk(req, sda_pull, exp_pull);
        ack_sample = 1; sda_in = ack_lvl; tick();
        ack_sample = 0; ack_phase = 0; sda_in = 1;
        chk("R8 capture", last_rx_ack, ack_lvl);
        tick();
        chk("R7 release after slot", sda_pull, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk("R1 pull", sda_pull, 1'b0);
        chk("R1 last ack", last_rx_ack, 1'b1);
        chk("R1 pulse", irq_pulse, 1'b0);
        chk("R1 pend", irq_pend, 1'b0);
        rst_n = 1; tick();

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][14]) pulse_start();
            is_master = VEC[i][13]; is_receiver = VEC[i][12];
            addr_ack_dis = VEC[i][3]; gc_ack_en = VEC[i][2]; data_ack_en = VEC[i][1];
            run_byte(VEC[i][11:4], VEC[i][0], logic'(i % 2), $sformatf("R2-R5/R7 vector %0d", i));
            irq_clr = 1; tick(); irq_clr = 0;
        end

        // R6: STOP removes the address match
        is_master = 0; is_receiver = 1; addr_ack_dis = 0; data_ack_en = 1;
        pulse_start();
        run_byte(8'h74, 1'b1, 1'b0, "R6 address before stop");
        pulse_stop();
        run_byte(8'h10, 1'b0, 1'b0, "R6 data after stop");
        // R6: repeated START needs a fresh match (0x42 mismatches)
        pulse_start();
        run_byte(8'h74, 1'b1, 1'b0, "R6 address");
        pulse_start();
        run_byte(8'h42, 1'b0, 1'b1, "R6 repeated start mismatch");
        run_byte(8'h20, 1'b0, 1'b0, "R6 data after repeated start");

        // R8: no sample holds the value
        repeat (3) tick();
        chk("R8 hold", last_rx_ack, 1'b0);

        // R11: enable raised late inside the slot, master receiver
        irq_clr = 1; tick(); irq_clr = 0;
        is_master = 1; is_receiver = 1; data_ack_en = 0;
        rx_byte = 8'hA5; byte_done = 1; tick(); byte_done = 0;
        ack_phase = 1; tick();
        chk("R11 nack before enable", sda_pull, 1'b0);
        data_ack_en = 1; tick();
        chk("R11 ack after enable", sda_pull, 1'b1);
        ack_phase = 0; tick();
        chk("R7 release", sda_pull, 1'b0);

        // R9: eighth-clock interrupt, then switched to ninth within the byte
        irq_at_8th = 1;
        rx_byte = 8'h3C; byte_done = 1; tick(); byte_done = 0;
        chk("R9 eighth pulse", irq_pulse, 1'b1);
        irq_at_8th = 0; irq_clr = 1; ack_phase = 1; tick(); irq_clr = 0;
        chk("R9 single cycle", irq_pulse, 1'b0);
        chk("R10 cleared", irq_pend, 1'b0);
        ack_sample = 1; sda_in = 0; tick(); ack_sample = 0; ack_phase = 0; sda_in = 1;
        chk("R9 ninth pulse", irq_pulse, 1'b1);
        tick();
        // R9: ninth mode gives no pulse at byte_done
        rx_byte = 8'h3D; byte_done = 1; tick(); byte_done = 0;
        chk("R9 no eighth pulse", irq_pulse, 1'b0);
        chk("R10 pending held", irq_pend, 1'b1);
        // R10: event and clear together keep it pending
        ack_phase = 1; tick();
        ack_sample = 1; irq_clr = 1; tick(); ack_sample = 0; irq_clr = 0; ack_phase = 0;
        chk("R10 set beats clear", irq_pend, 1'b1);
        irq_clr = 1; tick(); irq_clr = 0;
        chk("R10 clear", irq_pend, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule